// File: doc/BRIEF.md
# Parallel Match Table

This block is a small content-addressable store. It holds a fixed number of words. A write puts one word into a chosen slot. A search compares a key against every slot at once. The result of a search says whether exactly one slot held the key, whether two or more slots held it, and which slot holds it.

Slots have no valid flag. Each slot is simply its stored word. Reset clears every slot to zero, so a search for zero straight after reset finds every slot.

The outputs are registered. A search sampled on one rising edge has its result on the outputs just after that edge. The result stays there until the next edge. When the cycle is not a search, the outputs go back to zero. Two parameters set the size: the number of slots and the word width. The default build has four slots of four bits.

Top module: `cam_match_array`

## Requirements
- R1: After reset, every slot holds zero and single_o, multi_o and addr_o are all 0.
- R2: A cycle with en_i low changes no slot, whatever we_i, addr_i and data_i carry. After that edge, single_o and multi_o are 0 and addr_o is 0.
- R3: A cycle with en_i and we_i both high stores data_i into the slot whose binary index is addr_i. After that edge, all three outputs are 0.
- R4: A search is a cycle with en_i high and we_i low. When exactly one slot equals data_i, single_o is 1, multi_o is 0 and addr_o is that slot's binary index.
- R5: A search that matches no slot gives single_o 0, multi_o 0 and addr_o 0.
- R6: A search that matches two or more slots gives multi_o 1 and single_o 0. In that case addr_o is the lowest matching index.
- R7: single_o and multi_o are never 1 at the same time.
- R8: A search leaves the slots unchanged. Repeating a search with the same key gives the same result.
- R9: A word written on one edge is seen by a search sampled on the very next edge.
- R10: Every result shows on the outputs after the rising edge that sampled the inputs. It then holds until the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operation enable |
| we_i | input | 1 | Write when 1, search when 0 (only while en_i is 1) |
| addr_i | input | AW | Slot index for a write |
| data_i | input | WIDTH | Word to write, or key to search for |
| single_o | output | 1 | Exactly one slot matched |
| multi_o | output | 1 | Two or more slots matched |
| addr_o | output | AW | Index of the match (the lowest one if several match) |

## Verification
Each operation's result is due exactly one rising edge after the inputs are driven. The outputs are then read on the falling edge that follows that rising edge. The driver changes the inputs on falling edges and waits for the sampling rising edge. Only then does it queue the result it predicts from a model of the slots. The monitor pops one item on each falling edge, so every comparison lands on the cycle its result belongs to. Repeated keys, ignored writes and back-to-back write-then-search sequences all go through the same queue. This shows that timing holds across both state changes and pure lookups.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_SEARCH = 2'd2
  } cam_op_e;

  function automatic cam_op_e decode_op(input logic en, input logic we);
    if (!en)    return OP_IDLE;
    else if (we) return OP_WRITE;
    else        return OP_SEARCH;
  endfunction

endpackage

// File: rtl/cam_store.sv
module cam_store #(
  parameter int ENTRIES = 4,
  parameter int WIDTH   = 4,
  parameter int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [AW-1:0]                   wr_addr_i,
  input  logic [WIDTH-1:0]                wr_data_i,
  output logic [ENTRIES-1:0][WIDTH-1:0]   slots_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == AW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  slots_o[g] <= '0;
      else if (sel) slots_o[g] <= wr_data_i;
    end
  end

endmodule

// File: rtl/cam_compare.sv
module cam_compare #(
  parameter int ENTRIES = 4,
  parameter int WIDTH   = 4
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] slots_i,
  input  logic [WIDTH-1:0]              key_i,
  output logic [ENTRIES-1:0]            hit_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = (slots_i[g] == key_i);
  end

endmodule

// File: rtl/cam_encode.sv
module cam_encode #(
  parameter int ENTRIES = 4,
  parameter int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] hit_i,
  output logic               one_o,
  output logic               many_o,
  output logic [AW-1:0]      idx_o
);

  logic found;

  always_comb begin
    found  = 1'b0;
    many_o = 1'b0;
    idx_o  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_i[i]) begin
        if (found) many_o = 1'b1;
        else       idx_o  = AW'(i);  // first hit from the bottom wins
        found = 1'b1;
      end
    end
    one_o = found && !many_o;
  end

endmodule

// File: rtl/cam_match_array.sv
module cam_match_array
  import cam_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int WIDTH   = 4,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             single_o,
  output logic             multi_o,
  output logic [AW-1:0]    addr_o
);

  cam_op_e                       op;
  logic [ENTRIES-1:0][WIDTH-1:0] slots;
  logic [ENTRIES-1:0]            hit;
  logic                          one, many;
  logic [AW-1:0]                 idx;

  assign op = decode_op(en_i, we_i);

  cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (op == OP_WRITE),
    .wr_addr_i (addr_i),
    .wr_data_i (data_i),
    .slots_o   (slots)
  );

  cam_compare #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_cmp (
    .slots_i (slots),
    .key_i   (data_i),
    .hit_o   (hit)
  );

  cam_encode #(.ENTRIES(ENTRIES), .AW(AW)) u_enc (
    .hit_i  (hit),
    .one_o  (one),
    .many_o (many),
    .idx_o  (idx)
  );

  // results only on a search; any other cycle clears them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_o <= 1'b0;
      multi_o  <= 1'b0;
      addr_o   <= '0;
    end else if (op == OP_SEARCH) begin
      single_o <= one;
      multi_o  <= many;
      addr_o   <= idx;
    end else begin
      single_o <= 1'b0;
      multi_o  <= 1'b0;
      addr_o   <= '0;
    end
  end

endmodule

// File: rtl/cam_match_array_chk.sv
module cam_match_array_chk #(
  parameter int ENTRIES = 4,
  parameter int WIDTH   = 4,
  parameter int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [WIDTH-1:0] data_i,
  input logic             single_o,
  input logic             multi_o,
  input logic [AW-1:0]    addr_o
);

  logic srch;
  assign srch = en_i && !we_i;

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(single_o && multi_o)); // R7

  AST_IDLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!single_o && !multi_o && addr_o == '0)); // R2

  AST_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |=> (!single_o && !multi_o && addr_o == '0)); // R3

  AST_MISS_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_o && !multi_o) |-> (addr_o == '0)); // R5

  AST_REPEAT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srch && $past(srch) && $stable(data_i)) |=>
      ($stable(single_o) && $stable(multi_o) && $stable(addr_o))); // R8

endmodule

bind cam_match_array cam_match_array_chk #(
  .ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .we_i(we_i),
  .addr_i(addr_i), .data_i(data_i),
  .single_o(single_o), .multi_o(multi_o), .addr_o(addr_o)
);

// File: tb/tb_cam_match_array.sv
`timescale 1ns/1ps
module tb_cam_match_array;

  localparam int ENTRIES = 4;
  localparam int WIDTH   = 4;
  localparam int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             we_i = 1'b0;
  logic [AW-1:0]    addr_i = '0;
  logic [WIDTH-1:0] data_i = '0;
  logic             single_o, multi_o;
  logic [AW-1:0]    addr_o;

  always #2.5 clk_i = ~clk_i;

  cam_match_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .we_i(we_i),
    .addr_i(addr_i), .data_i(data_i),
    .single_o(single_o), .multi_o(multi_o), .addr_o(addr_o)
  );

  typedef struct {
    logic          s;
    logic          m;
    logic [AW-1:0] a;
    string         tag;
  } exp_t;

  exp_t             sb_q[$];
  logic [WIDTH-1:0] model [ENTRIES];
  int               checks = 0;
  int               errors = 0;
  int               cycles = 0;
  bit               done   = 0;

  task automatic check(input string tag, input logic s, input logic m,
                       input logic [AW-1:0] a, input exp_t e);
    checks++;
    if (s !== e.s || m !== e.m || a !== e.a) begin
      errors++;
      $display("FAIL %s: got single=%0b multi=%0b addr=%0d, expected single=%0b multi=%0b addr=%0d",
               tag, s, m, a, e.s, e.m, e.a);
    end
  endtask

  // driver: drive on falling edge, predict from model, queue after sampling edge
  task automatic op(input logic en, input logic we, input int adr,
                    input int dat, input string tag);
    exp_t e;
    int   cnt;
    @(negedge clk_i);
    en_i = en; we_i = we; addr_i = AW'(adr); data_i = WIDTH'(dat);
    e.s = 0; e.m = 0; e.a = '0; e.tag = tag;
    if (en && !we) begin
      cnt = 0;
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (model[i] == WIDTH'(dat)) begin cnt++; e.a = AW'(i); end
      e.s = (cnt == 1);
      e.m = (cnt >= 2);
      if (cnt == 0) e.a = '0;
    end
    @(posedge clk_i);
    #0.5;
    if (en && we) model[adr] = WIDTH'(dat);
    sb_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, single_o, multi_o, addr_o, e);
      end
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 20000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got no finish, expected finish before 20000 cycles");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    exp_t z;
    z.s = 0; z.m = 0; z.a = '0; z.tag = "R1";
    for (int i = 0; i < ENTRIES; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    check("R1 reset outputs", single_o, multi_o, addr_o, z);
    rst_ni = 1'b1;

    op(0, 0, 0, 0, "R2 idle");
    op(1, 0, 0, 0, "R1 R6 zero key hits all slots");
    op(1, 0, 0, 1, "R5 miss");
    op(1, 1, 0, 4, "R3 write slot0");
    op(1, 0, 0, 4, "R4 R9 hit right after write");
    op(1, 0, 0, 4, "R8 repeat search");
    op(1, 0, 0, 5, "R5 miss after write");
    op(1, 1, 2, 9, "R3 write slot2");
    op(1, 1, 3, 9, "R3 write slot3");
    op(1, 0, 0, 9, "R6 multi lowest index 2");
    op(1, 1, 1, 9, "R3 write slot1");
    op(1, 0, 0, 9, "R6 multi lowest index 1");
    op(0, 1, 0, 7, "R2 disabled write");
    op(1, 0, 0, 4, "R2 slot0 unchanged");
    op(1, 0, 0, 7, "R2 disabled value absent");
    op(1, 1, 3, 15, "R3 write slot3 top");
    op(1, 0, 0, 15, "R4 hit slot3");
    op(1, 0, 2, 15, "R8 repeat with other addr");
    for (int v = 0; v < (1 << WIDTH); v++)
      op(1, 0, 0, v, "R7 R10 sweep");
    op(0, 0, 0, 0, "R10 idle after search");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule